// File: doc/BRIEF.md
# DMA Channel Interrupt Status Collector

This block gathers per-channel event pulses from a multi-channel DMA engine and sorts them into four cause classes: transfer-complete, source-side fault, destination-side fault and setup fault. Each class keeps one sticky pending bit per channel. Software sees every class twice: once unfiltered and once filtered by a per-channel enable vector that arrives on input ports. Pending bits are cleared only by writing ones through the unfiltered view. Any clear that arrives in the same cycle as a new event loses to that event.

The block also exposes a live view of which channels are busy. It holds two plain configuration words, a group-priority word and an arbitration word, and drives them out to the arbiter. A value of zero in the arbitration word selects equal priority for all channels. A single level-sensitive interrupt line is high while any filtered bit in any class is set. A small register bus with a registered read port gives software access to everything.

Top module: `dma_irq_status_ctrl`

## Requirements
- R1: After synchronous active-low reset, every pending bit, both configuration words, the read-data port and `irq` are zero.
- R2: A high bit i on a class's event input sets pending bit i of that class at the next clock edge. The unfiltered view of the classes is at 0x810 (complete), 0x814 (source fault), 0x818 (destination fault) and 0x81C (setup fault), with bit i meaning channel i.
- R3: The filtered view of a class, at 0x800, 0x804, 0x808 and 0x80C in the same class order, reads as the pending bits ANDed with that class's enable input.
- R4: A write to an unfiltered offset clears exactly the pending bits whose write-data bit is one and leaves the others and the other classes untouched. An all-ones write clears every channel of that class.
- R5: When an event bit and a clear of the same bit fall in the same cycle, the bit ends up set.
- R6: `irq` is the OR of all filtered bits of all four classes, registered, so it follows a change in pending or enable state one clock edge later.
- R7: A read of 0x820 returns the `ch_busy` input vector, with bit i meaning channel i.
- R8: Writes to the filtered offsets 0x800 to 0x80C and to the busy offset 0x820 change no state.
- R9: A read returns data on `bus_rdata` after the clock edge that accepts it. A read of any offset not listed in R2, R3, R7 or R10 returns zero.
- R10: The group-priority word at 0x824 and the arbitration word at 0x828 take the full write data, read back that value and drive `prio_cfg` and `arb_cfg`. They change only on a write to their own offset.
- R11: Without an event or a clearing write, pending bits hold their value indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| ev_tc | input | NCH | Per-channel transfer-complete event |
| ev_src_err | input | NCH | Per-channel source-fault event |
| ev_dst_err | input | NCH | Per-channel destination-fault event |
| ev_cfg_err | input | NCH | Per-channel setup-fault event |
| en_tc | input | NCH | Interrupt enable, complete class |
| en_src_err | input | NCH | Interrupt enable, source-fault class |
| en_dst_err | input | NCH | Interrupt enable, destination-fault class |
| en_cfg_err | input | NCH | Interrupt enable, setup-fault class |
| ch_busy | input | NCH | Live channel-busy vector |
| prio_cfg | output | DATA_W | Group-priority word |
| arb_cfg | output | DATA_W | Arbitration word (zero = equal priority) |
| irq | output | 1 | Combined interrupt, registered |

## Verification
Each result has a fixed latency. An event or a clearing write changes a pending bit at the edge that samples it. A read returns the state from before its own accepting edge one edge later. `irq` trails the pending and enable state by one further edge. The bench's driver pushes each read's expected value into a queue at the accepting edge, and the monitor pops and compares it at the following falling edge. Interrupt checks wait for one more rising edge after the stimulus task returns, then sample one time unit later. Because of this, every comparison lands in the cycle in which the result is due and never on a clock edge.

// File: rtl/dma_irq_pkg.sv
// Package: shared constants and types for the DMA interrupt status collector.
// Assumes byte addressing with 32-bit register spacing.
package dma_irq_pkg;

    localparam int NUM_CLASS = 4;

    // Cause class index; order fixes the register layout (4-byte stride).
    typedef enum logic [1:0] {
        CLS_DONE    = 2'd0,
        CLS_SRC_ERR = 2'd1,
        CLS_DST_ERR = 2'd2,
        CLS_CFG_ERR = 2'd3
    } cause_cls_e;

    localparam int OFS_MASKED_BASE = 'h800;
    localparam int OFS_RAW_BASE    = 'h810;
    localparam int OFS_BUSY        = 'h820;
    localparam int OFS_PRIO        = 'h824;
    localparam int OFS_ARB         = 'h828;
    localparam int OFS_STRIDE      = 4;

endpackage

// File: rtl/dis_cause_bank.sv
// Module: one cause class. Keeps a sticky pending bit per channel, set by
// an event pulse and cleared by a write-ones strobe; an event wins over a
// clear in the same cycle. Produces the enable-filtered view.
// Assumes clr_i is a single-cycle strobe qualified by the bus decoder.
module dis_cause_bank #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] event_i,
    input  logic           clr_i,
    input  logic [NCH-1:0] clr_bits_i,
    input  logic [NCH-1:0] enable_i,
    output logic [NCH-1:0] raw_o,
    output logic [NCH-1:0] masked_o
);

    logic [NCH-1:0] pend_q;
    logic [NCH-1:0] clr_vec;

    // Purpose: expand the clear strobe to a per-channel vector.
    always_comb begin
        clr_vec = clr_i ? clr_bits_i : '0;
    end

    // Purpose: per-channel sticky bit, event has priority over clear.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[ch] <= 1'b0;
            end else if (event_i[ch]) begin
                pend_q[ch] <= 1'b1;
            end else if (clr_vec[ch]) begin
                pend_q[ch] <= 1'b0;
            end
        end
    end

    // Purpose: filtered view for the interrupt line and readback.
    always_comb begin
        raw_o    = pend_q;
        masked_o = pend_q & enable_i;
    end

endmodule

// File: rtl/dis_bus_decode.sv
// Module: register bus decoder. Turns writes into clear strobes and
// configuration-word enables, and registers read data from a mux.
// Assumes one access per cycle and NCH <= DATA_W; unmapped reads give zero.
module dis_bus_decode
    import dma_irq_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_en,
    input  logic                              bus_we,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [NUM_CLASS-1:0][NCH-1:0]     raw_i,
    input  logic [NUM_CLASS-1:0][NCH-1:0]     masked_i,
    input  logic [NCH-1:0]                    busy_i,
    input  logic [DATA_W-1:0]                 prio_i,
    input  logic [DATA_W-1:0]                 arb_i,
    output logic [NUM_CLASS-1:0]              raw_clr_o,
    output logic                              prio_we_o,
    output logic                              arb_we_o,
    output logic [DATA_W-1:0]                 rdata_o
);

    logic                wr_acc;
    logic                rd_acc;
    logic [DATA_W-1:0]   rd_mux;
    logic [DATA_W-1:0]   rd_q;

    // Purpose: qualify the access type.
    always_comb begin
        wr_acc = bus_en &  bus_we;
        rd_acc = bus_en & ~bus_we;
    end

    // Purpose: write decode; filtered and busy offsets get no strobe.
    always_comb begin
        for (int c = 0; c < NUM_CLASS; c++) begin
            raw_clr_o[c] = wr_acc &&
                (bus_addr == ADDR_W'(OFS_RAW_BASE + c * OFS_STRIDE));
        end
        prio_we_o = wr_acc && (bus_addr == ADDR_W'(OFS_PRIO));
        arb_we_o  = wr_acc && (bus_addr == ADDR_W'(OFS_ARB));
    end

    // Purpose: read mux over every mapped offset, zero elsewhere.
    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NUM_CLASS; c++) begin
            if (bus_addr == ADDR_W'(OFS_MASKED_BASE + c * OFS_STRIDE)) begin
                rd_mux = DATA_W'(masked_i[c]);
            end
            if (bus_addr == ADDR_W'(OFS_RAW_BASE + c * OFS_STRIDE)) begin
                rd_mux = DATA_W'(raw_i[c]);
            end
        end
        if (bus_addr == ADDR_W'(OFS_BUSY)) begin
            rd_mux = DATA_W'(busy_i);
        end
        if (bus_addr == ADDR_W'(OFS_PRIO)) begin
            rd_mux = prio_i;
        end
        if (bus_addr == ADDR_W'(OFS_ARB)) begin
            rd_mux = arb_i;
        end
    end

    // Purpose: registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_acc) begin
            rd_q <= rd_mux;
        end
    end

    assign rdata_o = rd_q;

endmodule

// File: rtl/dis_cfg_word.sv
// Module: a plain software-written configuration word with reset to zero.
// Assumes the write enable is already address-qualified.
module dis_cfg_word #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] value_o
);

    logic [DATA_W-1:0] word_q;

    // Purpose: load on write, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (we_i) begin
            word_q <= wdata_i;
        end
    end

    assign value_o = word_q;

endmodule

// File: rtl/dis_irq_merge.sv
// Module: reduces all filtered bits of all classes to one registered line.
// Assumes the line is level-sensitive at the interrupt controller.
module dis_irq_merge
    import dma_irq_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CLASS-1:0][NCH-1:0] masked_i,
    output logic                          irq_o
);

    logic any_set;
    logic irq_q;

    // Purpose: OR across classes and channels.
    always_comb begin
        any_set = 1'b0;
        for (int c = 0; c < NUM_CLASS; c++) begin
            any_set = any_set | (|masked_i[c]);
        end
    end

    // Purpose: register the combined line for a clean output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= any_set;
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/dma_irq_status_ctrl.sv
// Module: top of the DMA interrupt status collector. Packs the four event
// and enable vectors into class arrays, instantiates one cause bank per
// class, the bus decoder, two configuration words and the interrupt merge.
// Assumes NCH <= DATA_W and single-clock operation.
module dma_irq_status_ctrl
    import dma_irq_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCH-1:0]    ev_tc,
    input  logic [NCH-1:0]    ev_src_err,
    input  logic [NCH-1:0]    ev_dst_err,
    input  logic [NCH-1:0]    ev_cfg_err,
    input  logic [NCH-1:0]    en_tc,
    input  logic [NCH-1:0]    en_src_err,
    input  logic [NCH-1:0]    en_dst_err,
    input  logic [NCH-1:0]    en_cfg_err,
    input  logic [NCH-1:0]    ch_busy,
    output logic [DATA_W-1:0] prio_cfg,
    output logic [DATA_W-1:0] arb_cfg,
    output logic              irq
);

    logic [NUM_CLASS-1:0][NCH-1:0] ev_all;
    logic [NUM_CLASS-1:0][NCH-1:0] en_all;
    logic [NUM_CLASS-1:0][NCH-1:0] raw_all;
    logic [NUM_CLASS-1:0][NCH-1:0] masked_all;
    logic [NUM_CLASS-1:0]          raw_clr;
    logic                          prio_we;
    logic                          arb_we;

    // Purpose: pack per-class ports in register-layout order.
    always_comb begin
        ev_all[CLS_DONE]    = ev_tc;
        ev_all[CLS_SRC_ERR] = ev_src_err;
        ev_all[CLS_DST_ERR] = ev_dst_err;
        ev_all[CLS_CFG_ERR] = ev_cfg_err;
        en_all[CLS_DONE]    = en_tc;
        en_all[CLS_SRC_ERR] = en_src_err;
        en_all[CLS_DST_ERR] = en_dst_err;
        en_all[CLS_CFG_ERR] = en_cfg_err;
    end

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
        dis_cause_bank #(.NCH(NCH)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .event_i    (ev_all[c]),
            .clr_i      (raw_clr[c]),
            .clr_bits_i (bus_wdata[NCH-1:0]),
            .enable_i   (en_all[c]),
            .raw_o      (raw_all[c]),
            .masked_o   (masked_all[c])
        );
    end

    dis_bus_decode #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .raw_i     (raw_all),
        .masked_i  (masked_all),
        .busy_i    (ch_busy),
        .prio_i    (prio_cfg),
        .arb_i     (arb_cfg),
        .raw_clr_o (raw_clr),
        .prio_we_o (prio_we),
        .arb_we_o  (arb_we),
        .rdata_o   (bus_rdata)
    );

    dis_cfg_word #(.DATA_W(DATA_W)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (prio_we),
        .wdata_i (bus_wdata),
        .value_o (prio_cfg)
    );

    dis_cfg_word #(.DATA_W(DATA_W)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (arb_we),
        .wdata_i (bus_wdata),
        .value_o (arb_cfg)
    );

    dis_irq_merge #(.NCH(NCH)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .masked_i (masked_all),
        .irq_o    (irq)
    );

endmodule

// File: rtl/dis_checker.sv
// Module: temporal checks for the DMA interrupt status collector, bound
// to the top module. Observes ports and the packed class arrays.
module dis_checker
    import dma_irq_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_en,
    input logic                          bus_we,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [NUM_CLASS-1:0][NCH-1:0] ev_all,
    input logic [NUM_CLASS-1:0][NCH-1:0] raw_all,
    input logic [NUM_CLASS-1:0][NCH-1:0] masked_all,
    input logic [DATA_W-1:0]             prio_cfg,
    input logic [DATA_W-1:0]             arb_cfg,
    input logic                          irq
);

    logic wr_acc;
    logic ro_write;

    // Purpose: classify the current bus access.
    always_comb begin
        wr_acc   = bus_en & bus_we;
        ro_write = wr_acc && ((bus_addr == ADDR_W'(OFS_BUSY)) ||
                   ((bus_addr >= ADDR_W'(OFS_MASKED_BASE)) &&
                    (bus_addr <  ADDR_W'(OFS_RAW_BASE))));
    end

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_all) |=> ((raw_all & $past(ev_all)) == $past(ev_all))); // R2

    AST_RISE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_all & ~$past(raw_all) & ~$past(ev_all)) == '0)); // R2

    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ev_all) && wr_acc) |=> ((raw_all & $past(ev_all)) == $past(ev_all))); // R5

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|masked_all))); // R6

    AST_RO_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (ro_write && !(|ev_all)) |=> $stable(raw_all)); // R8

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_acc |=> ($stable(prio_cfg) && $stable(arb_cfg))); // R10

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|ev_all) && !wr_acc) |=> $stable(raw_all)); // R11

endmodule

bind dma_irq_status_ctrl dis_checker #(
    .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_dis_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .ev_all     (ev_all),
    .raw_all    (raw_all),
    .masked_all (masked_all),
    .prio_cfg   (prio_cfg),
    .arb_cfg    (arb_cfg),
    .irq        (irq)
);

// File: tb/dma_irq_status_ctrl_bench.sv
// Bench: scoreboard style. Driver tasks push expected read data at the
// accepting edge; a monitor pops and compares at the next falling edge.
module dma_irq_status_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCH    = 8;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    typedef struct {
        logic [DATA_W-1:0] exp;
        string             tag;
    } sb_item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_en = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [NCH-1:0]    ev_tc = '0, ev_src = '0, ev_dst = '0, ev_cfg = '0;
    logic [NCH-1:0]    en_tc = '0, en_src = '0, en_dst = '0, en_cfg = '0;
    logic [NCH-1:0]    ch_busy = '0;
    logic [DATA_W-1:0] prio_cfg, arb_cfg;
    logic              irq;

    int n_chk  = 0;
    int n_fail = 0;
    sb_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_irq_status_ctrl #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dma_irq_status_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_tc(ev_tc), .ev_src_err(ev_src), .ev_dst_err(ev_dst), .ev_cfg_err(ev_cfg),
        .en_tc(en_tc), .en_src_err(en_src), .en_dst_err(en_dst), .en_cfg_err(en_cfg),
        .ch_busy(ch_busy), .prio_cfg(prio_cfg), .arb_cfg(arb_cfg), .irq(irq)
    );

    task automatic check(input string tag, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare the oldest pending read one half-cycle after it is due.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            check(it.tag, bus_rdata, it.exp);
        end
    end

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp,
                            input string tag);
        sb_item_t it;
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk);
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        #1 bus_en = 1'b0;
    endtask

    task automatic fire(input int cls, input logic [NCH-1:0] bits);
        @(negedge clk);
        case (cls)
            0: ev_tc  = bits;
            1: ev_src = bits;
            2: ev_dst = bits;
            default: ev_cfg = bits;
        endcase
        @(posedge clk);
        #1 begin ev_tc = '0; ev_src = '0; ev_dst = '0; ev_cfg = '0; end
    endtask

    task automatic check_irq(input logic exp, input string tag);
        @(posedge clk);
        #1 check(tag, DATA_W'(irq), DATA_W'(exp));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        check("R1 irq", DATA_W'(irq), '0);
        check("R1 rdata", bus_rdata, '0);
        bus_read(12'h810, 32'h0, "R1 raw done");
        bus_read(12'h814, 32'h0, "R1 raw src");
        bus_read(12'h818, 32'h0, "R1 raw dst");
        bus_read(12'h81C, 32'h0, "R1 raw cfg");
        bus_read(12'h824, 32'h0, "R1 prio");
        bus_read(12'h828, 32'h0, "R1 arb");

        // R2/R3/R6: event with enables off
        fire(0, 8'h05);
        bus_read(12'h810, 32'h05, "R2 raw done set");
        bus_read(12'h800, 32'h00, "R3 masked done, enable off");
        check_irq(1'b0, "R6 irq low while disabled");

        // R3/R6: enable one pending channel
        @(negedge clk); en_tc = 8'h04;
        bus_read(12'h800, 32'h04, "R3 masked done filtered");
        check_irq(1'b1, "R6 irq high");

        // R2: other classes, distinct channels
        fire(1, 8'h80);
        fire(2, 8'h01);
        fire(3, 8'h40);
        bus_read(12'h814, 32'h80, "R2 raw src");
        bus_read(12'h818, 32'h01, "R2 raw dst");
        bus_read(12'h81C, 32'h40, "R2 raw cfg");

        // R4: partial write-ones clear
        bus_write(12'h810, 32'h04);
        bus_read(12'h810, 32'h01, "R4 partial clear");
        bus_read(12'h814, 32'h80, "R4 other class untouched");
        check_irq(1'b0, "R6 irq drops after clear");

        // R5: event and clear of same bit in one cycle
        @(negedge clk);
        ev_tc = 8'h02;
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 12'h810; bus_wdata = 32'h03;
        @(posedge clk);
        #1 begin ev_tc = '0; bus_en = 1'b0; bus_we = 1'b0; end
        bus_read(12'h810, 32'h02, "R5 event wins over clear");

        // R8: writes to filtered and busy offsets ignored
        @(negedge clk); en_tc = 8'hFF;
        bus_write(12'h800, 32'hFFFF_FFFF);
        bus_write(12'h804, 32'hFFFF_FFFF);
        bus_write(12'h820, 32'hFFFF_FFFF);
        bus_read(12'h810, 32'h02, "R8 raw done unchanged");
        bus_read(12'h814, 32'h80, "R8 raw src unchanged");
        bus_read(12'h800, 32'h02, "R8 masked done unchanged");

        // R7: busy vector
        @(negedge clk); ch_busy = 8'hA5;
        bus_read(12'h820, 32'hA5, "R7 busy A5");
        @(negedge clk); ch_busy = 8'h3C;
        bus_read(12'h820, 32'h3C, "R7 busy 3C");

        // R10: configuration words
        bus_write(12'h824, 32'h1234_5678);
        bus_write(12'h828, 32'h0000_0003);
        bus_read(12'h824, 32'h1234_5678, "R10 prio readback");
        bus_read(12'h828, 32'h0000_0003, "R10 arb readback");
        @(negedge clk);
        check("R10 prio port", prio_cfg, 32'h1234_5678);
        check("R10 arb port", arb_cfg, 32'h3);

        // R9: unmapped reads
        bus_read(12'h830, 32'h0, "R9 unmapped 830");
        bus_read(12'h018, 32'h0, "R9 unmapped 018");
        bus_read(12'h82C, 32'h0, "R9 unmapped 82C");

        // R11: idle hold
        repeat (20) @(negedge clk);
        bus_read(12'h814, 32'h80, "R11 src held");
        bus_read(12'h81C, 32'h40, "R11 cfg held");

        // R4: all-ones clear of every class
        @(negedge clk); en_src = 8'hFF; en_dst = 8'hFF; en_cfg = 8'hFF;
        bus_write(12'h810, 32'hFFFF_FFFF);
        bus_write(12'h814, 32'hFFFF_FFFF);
        bus_write(12'h818, 32'hFFFF_FFFF);
        bus_write(12'h81C, 32'hFFFF_FFFF);
        bus_read(12'h810, 32'h0, "R4 all clear done");
        bus_read(12'h814, 32'h0, "R4 all clear src");
        bus_read(12'h818, 32'h0, "R4 all clear dst");
        bus_read(12'h81C, 32'h0, "R4 all clear cfg");
        check_irq(1'b0, "R6 irq low after full clear");

        // R6: a single setup-fault event raises irq one edge after it lands
        fire(3, 8'h01);
        check_irq(1'b1, "R6 irq from cfg class");

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule